// File: doc/BRIEF.md
# Gated Down Counter with Compare

A synchronous down counter with a programmable period, a hidden count register and a compare register. The counter runs only while the enable bit is set and the gate input is high. When the count reaches zero it reloads from the period register on the next clock, so one full period spans period + 1 counting clocks. A host reaches the registers through a small address/data port: the period register is write-only, the compare register is readable and writable at any time, and the count register cannot be read directly.

The block drives two outputs. The primary output is the comparison of the live count against the compare register, either strictly less than or less than or equal. The auxiliary output is the terminal-count pulse, either for the whole clock in which the count is zero or only for the low phase of that clock. An interrupt line follows one of these two sources, as chosen by a mode bit. To inspect the count, the host stops the counter (gate low or enable clear) and reads the count address. The bus then returns zero, and the count is copied into the compare register, where it can be read back.

Top module: `gated_down_counter`

## Requirements
- R1: While `en` is low, a write to address 1 (period) also loads the written value into the count register on the same clock edge.
- R2: While `en` and `gate` are high, the count falls by one per clock. At zero it reloads from the period register on the next clock, so a period value P gives P + 1 clocks per cycle.
- R3: A period written while `en` is high leaves the running count untouched. The new value enters the count only at the reload that follows the terminal count.
- R4: While `gate` is low, the count holds its value, no reload happens, and `aux_out` and the terminal-count interrupt stay low even at count zero.
- R5: A read (`rd_en`) of address 0 always returns 0 on `rdata`. When `en` is low or `gate` is low, the read also copies the count into the compare register on that clock. When the counter is running, the read leaves the compare register unchanged.
- R6: The compare register at address 2 can be written whether `en` is high or low. `rdata` shows it whenever `addr` is 2.
- R7: `prim_out` is high only when `en` is high and the compare holds. With `cmp_type` 0 the test is count < compare; with `cmp_type` 1 the test is count <= compare.
- R8: With `tc_full` 1, `aux_out` is high for the whole clock period in which `en` and `gate` are high and the count is 0. A period of 0 keeps it constantly high.
- R9: With `tc_full` 0, `aux_out` is high only during the low phase of such a clock. A period of 0 makes it the inverse of `clk`.
- R10: `irq` follows the full-clock terminal-count condition when `irq_sel` is 0, and follows `prim_out` when `irq_sel` is 1.
- R11: After reset, the count, period and compare registers are 0, and `prim_out`, `aux_out` and `irq` are low.
- R12: Address 1 reads back as 0 (the period register is write-only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable bit |
| gate | input | 1 | Count qualifier; the counter runs only while high |
| cmp_type | input | 1 | 0: count < compare, 1: count <= compare |
| tc_full | input | 1 | 1: full-clock terminal count, 0: low-phase-only |
| irq_sel | input | 1 | 0: interrupt on terminal count, 1: interrupt on compare |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | 0 count, 1 period, 2 compare |
| wdata | input | W | Write data |
| rdata | output | W | Read data (combinational) |
| prim_out | output | 1 | Compare result |
| aux_out | output | 1 | Terminal-count output |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, count steps, reloads and snapshots land on the first rising edge after the strobe. The bench drives every input 1 ns after a rising edge and samples 1 ns after the following rising edge. `rdata`, `prim_out` and `irq` are combinational from registers and mode inputs, so they are checked in the same cycle, 1 ns after their inputs change. The half-cycle terminal count is checked in both clock phases: 1 ns after the rising edge, where it must be low, and 1 ns after the falling edge, where it must be high. The bench reads the count only through the snapshot path, with the gate held low so the count cannot move in between.

// File: rtl/gated_down_counter.sv
module gated_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         gate,
  input  logic         cmp_type,
  input  logic         tc_full,
  input  logic         irq_sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         prim_out,
  output logic         aux_out,
  output logic         irq
);
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_PER = 2'd1;
  localparam logic [1:0] A_CMP = 2'd2;

  logic [W-1:0] count, period, cmpr;
  logic run, tc, stopped, cmp_hit;

  assign run     = en && gate;
  assign stopped = !run;
  assign tc      = run && (count == '0);
  assign cmp_hit = cmp_type ? (count <= cmpr) : (count < cmpr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!en) begin
      if (wr_en && addr == A_PER) count <= wdata;
    end else if (gate) begin
      if (count == '0) count <= period;
      else             count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      period <= '0;
    else if (wr_en && addr == A_PER) period <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cmpr <= '0;
    else if (wr_en && addr == A_CMP)            cmpr <= wdata;
    else if (rd_en && addr == A_CNT && stopped) cmpr <= count;
  end

  assign rdata    = (addr == A_CMP) ? cmpr : '0;
  assign prim_out = en && cmp_hit;
  assign aux_out  = tc_full ? tc : (tc && !clk);
  assign irq      = irq_sel ? prim_out : tc;
endmodule

module gated_down_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         gate,
  input logic         wr_en,
  input logic         rd_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] count,
  input logic [W-1:0] period,
  input logic [W-1:0] cmpr,
  input logic         prim_out
);
  a_r1_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && wr_en && addr == 2'd1) |=> count == $past(wdata));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate && count != '0) |=> count == $past(count) - 1'b1);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate && count == '0) |=> count == $past(period));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !gate) |=> $stable(count));
  a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |-> rdata == '0);
  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd0 && (!en || !gate)) |=> cmpr == $past(count));
  a_r6_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> cmpr == $past(wdata));
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !prim_out);
endmodule

bind gated_down_counter gated_down_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gate(gate), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .count(count), .period(period),
  .cmpr(cmpr), .prim_out(prim_out)
);

// File: tb/tb_gated_down_counter.sv
module tb_gated_down_counter;
  localparam int W = 8;
  localparam int K_RD = 0, K_PRIM = 1, K_AUX = 2, K_IRQ = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, gate = 0, cmp_type = 0, tc_full = 1, irq_sel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic prim_out, aux_out, irq;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {string req; int kind; logic [W-1:0] exp;} item_t;
  item_t q[$];
  event chk_ev;

  gated_down_counter #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .gate(gate), .cmp_type(cmp_type),
    .tc_full(tc_full), .irq_sel(irq_sel), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .prim_out(prim_out),
    .aux_out(aux_out), .irq(irq)
  );

  always #4 clk = ~clk;

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = rdata;
          K_PRIM:  act = {{(W-1){1'b0}}, prim_out};
          K_AUX:   act = {{(W-1){1'b0}}, aux_out};
          default: act = {{(W-1){1'b0}}, irq};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input string req, input int kind, input logic [W-1:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
    -> chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1;
    tick();
    wr_en = 0;
  endtask

  // gate low, read count address, then read the copy at the compare address
  task automatic snap(input string req, input logic [W-1:0] exp);
    gate = 0; addr = 2'd0; rd_en = 1; #1;
    expect_v("R5", K_RD, '0);
    tick();
    rd_en = 0; addr = 2'd2; #1;
    expect_v(req, K_RD, exp);
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      report();
    end
  end

  initial begin : driver
    tick(3);
    rst_n = 1;
    tick();
    // R11 reset state
    addr = 2'd2; #1;
    expect_v("R11", K_RD, '0);
    expect_v("R11", K_PRIM, 0);
    expect_v("R11", K_AUX, 0);
    expect_v("R11", K_IRQ, 0);
    addr = 2'd1; #1;
    expect_v("R12", K_RD, '0);

    // R1 load while disabled
    wr(2'd1, 8'd5);
    snap("R1", 8'd5);

    // R2 decrement and reload
    en = 1; gate = 1;
    tick(3);
    snap("R2", 8'd2);
    gate = 1;
    tick(2);
    expect_v("R8", K_AUX, 1);
    expect_v("R10", K_IRQ, 1);
    tick();
    expect_v("R8", K_AUX, 0);
    snap("R2", 8'd5);

    // R3 period written while running
    gate = 1;
    wr(2'd1, 8'd2);
    snap("R3", 8'd4);
    gate = 1;
    tick(5);
    snap("R3", 8'd2);

    // R4 gate low holds
    tick(5);
    snap("R4", 8'd2);
    gate = 1;
    tick(2);
    gate = 0; #1;
    expect_v("R4", K_AUX, 0);
    expect_v("R4", K_IRQ, 0);
    tick(3);
    snap("R4", 8'd0);

    // R6, R7 compare
    wr(2'd2, 8'd3);
    addr = 2'd2; #1;
    expect_v("R6", K_RD, 8'd3);
    cmp_type = 0; #1;
    expect_v("R7", K_PRIM, 1);
    en = 0; #1;
    expect_v("R7", K_PRIM, 0);
    wr(2'd1, 8'd3);
    en = 1; #1;
    expect_v("R7", K_PRIM, 0);
    cmp_type = 1; #1;
    expect_v("R7", K_PRIM, 1);
    wr(2'd2, 8'd2);
    expect_v("R7", K_PRIM, 0);
    irq_sel = 1; #1;
    expect_v("R10", K_IRQ, 0);
    cmp_type = 0;
    wr(2'd2, 8'd4);
    expect_v("R7", K_PRIM, 1);
    expect_v("R10", K_IRQ, 1);

    // R9, R8 period zero, R5 read while running
    irq_sel = 0; en = 0;
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd7);
    en = 1; gate = 1; tc_full = 0;
    tick(2);
    expect_v("R9", K_AUX, 0);
    expect_v("R10", K_IRQ, 1);
    @(negedge clk); #1;
    expect_v("R9", K_AUX, 1);
    tc_full = 1; #1;
    expect_v("R8", K_AUX, 1);
    tick();
    expect_v("R8", K_AUX, 1);
    addr = 2'd0; rd_en = 1; #1;
    expect_v("R5", K_RD, '0);
    tick();
    rd_en = 0; addr = 2'd2; #1;
    expect_v("R5", K_RD, 8'd7);

    done = 1;
    report();
  end
endmodule